// File: doc/BRIEF.md
# Low-Frequency Watchdog Timer

A watchdog peripheral for a slow 32 kHz-class tick domain, reached through a small bank of 16-bit registers. Software loads a timeout in half-second units and sets the enable bit. From then on the down counter runs and cannot be stopped. Software keeps the system alive by writing two fixed key words, in order, to the service register. If the counter runs out, the block issues a reset pulse. A control bit routes that pulse either to an internal reset request or to an active-low external reset pin. A status register records what caused the last reset the block issued.

An optional pretimeout interrupt can be raised a programmable number of half-seconds before expiry. Its flag is cleared by writing 1 to it. The block also has two direct reset controls in the control word, both active-low. A software-reset bit only acts when two writes fall within one tick period. An external-reset bit drives the pin at once. The low-power suspend bit can be written exactly once. When that bit is set and the low-power input is high, counting pauses. A power-up counter starts at reset and pulses the external pin when it runs out, unless software disables it for good by writing 0 to the miscellaneous register.

`tick_i` is a one-cycle enable for each slow-clock period. All state is in the fast `clk` domain, with synchronous active-high reset.

Top module: `lf_watchdog`

## Requirements
- R1: After reset, the registers read as follows: control reads 0x0030 (both active-low reset bits read 1, everything else 0), status reads 0x0000, interrupt control reads 0x0000 and miscellaneous reads 0x0001. `int_rst_o` and `irq_o` are 0 and `ext_rst_n_o` is 1. Reads return the register at `addr_i` one cycle after the address is presented.
- R2: Control register (offset 0x0) fields are: bits 15:8 timeout n, bit 5 external-reset request (active-low), bit 4 software-reset request (active-low), bit 3 route, bit 2 enable, bit 0 suspend. Once enabled with timeout n, the block expires after (n+1) half-second periods. One period is TICKS_PER_HALF ticks.
- R3: A write of 0x5555 to the service register (offset 0x2), followed directly by a write of 0xAAAA to the same register, reloads the counter and restarts the half-second phase. The next expiry is then (n+1) half-seconds later.
- R4: Any other service write, or the two keys in the wrong order, does not reload the counter. This includes 0xAAAA without a 0x5555 just before it, and 0x5555 followed by another value and then 0xAAAA.
- R5: Once the enable bit is 1, writing 0 to it has no effect: it reads back as 1 and the counter keeps running.
- R6: The suspend bit takes the value of the first control write after reset. Later writes leave it unchanged.
- R7: While suspend is 1 and `lowpwr_i` is 1, the counter and its half-second phase hold. With suspend at 0, `lowpwr_i` has no effect.
- R8: Interrupt control (offset 0x6) fields are: bit 15 enable, bit 14 flag, bits 7:0 pretimeout p. With the enable bit set, the flag is set p half-seconds before expiry, and `irq_o` is 1 while both the enable bit and the flag are 1. Writing 1 to bit 14 clears the flag. With the enable bit clear, the flag is never set.
- R9: When route is 0, an expiry asserts `int_rst_o`. When route is 1, an expiry drives `ext_rst_n_o` low instead. Each reset pulse lasts exactly PULSE_TICKS ticks.
- R10: Status (offset 0x4) bit 1 is set by an expiry and bit 0 by a software reset. Each event clears the other bit.
- R11: Writing 0 to control bit 4 asserts `int_rst_o` only if a second such write arrives before the next tick. A tick between the two writes cancels the request.
- R12: Writing 0 to control bit 5 drives `ext_rst_n_o` low at once, for PULSE_TICKS ticks.
- R13: The power-up counter drives `ext_rst_n_o` low on tick PD_TICKS after reset, unless 0 has been written to the miscellaneous register (offset 0x8). That write clears its bit 0 permanently: later nonzero writes do not set it again.
- R14: A new timeout written while the counter runs does not change the current period. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe per slow-clock period |
| lowpwr_i | input | 1 | Low-power state indication |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte offset for writes and reads |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| irq_o | output | 1 | Pretimeout interrupt |
| int_rst_o | output | 1 | Internal reset request, active-high |
| ext_rst_n_o | output | 1 | External reset pin, active-low |

## Verification
The bench builds the block with TICKS_PER_HALF=4, PULSE_TICKS=4 and PD_TICKS=20. With these values every timeout from 0 to 5 expires within 24 ticks. This makes it possible to sweep every timeout in that range against every pretimeout not larger than it, checking both the interrupt tick and the expiry tick arithmetically. The short power-up limit and pulse length let the bench also cover pulse widths, phase restart on a service reload, and pausing across several ticks. It also checks the permanent disable of the power-up counter.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 16;
  localparam int FW = 8;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_SVC  = 4'h2;
  localparam logic [3:0] OFS_STAT = 4'h4;
  localparam logic [3:0] OFS_IRQ  = 4'h6;
  localparam logic [3:0] OFS_MISC = 4'h8;

  localparam int B_SUSP  = 0;
  localparam int B_EN    = 2;
  localparam int B_ROUTE = 3;
  localparam int B_SWRN  = 4;
  localparam int B_EXTN  = 5;
  localparam int B_IEN   = 15;
  localparam int B_IFLG  = 14;

  localparam logic [DW-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [DW-1:0] KEY_SECOND = 16'hAAAA;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int TPH = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic half_o
);
  localparam int PW = (TPH > 1) ? $clog2(TPH) : 1;

  logic [PW-1:0] pc_q;
  logic          wrap;

  assign wrap   = (pc_q == PW'(TPH - 1));
  assign half_o = tick_i & run_i & wrap & ~clr_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) pc_q <= '0;
    else if (tick_i && run_i) pc_q <= wrap ? '0 : pc_q + 1'b1;
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clr_i) |=> $stable(pc_q)); // R7
endmodule

// File: rtl/wdt_svc_seq.sv
module wdt_svc_seq
  import wdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          kick_o
);
  logic armed_q;

  assign kick_o = wr_i & (data_i == KEY_SECOND) & armed_q;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else if (wr_i) armed_q <= (data_i == KEY_FIRST);
  end

  AST_KICK_DISARMS: assert property (@(posedge clk) disable iff (rst)
    kick_o |=> !armed_q); // R3
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic start_i,
  output logic active_o
);
  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      n_q      <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      n_q      <= LW'(LEN);
    end else if (active_o && tick_i) begin
      if (n_q == LW'(1)) active_o <= 1'b0;
      n_q <= n_q - 1'b1;
    end
  end

  AST_PULSE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(active_o) |-> $past(tick_i)); // R9
endmodule

// File: rtl/lf_watchdog.sv
module lf_watchdog
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_HALF = 16384,
  parameter int PULSE_TICKS    = 4,
  parameter int PD_TICKS       = 65536
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          lowpwr_i,
  input  logic          wr_en_i,
  input  logic [3:0]    addr_i,
  input  logic [15:0]   wr_data_i,
  output logic [15:0]   rd_data_o,
  output logic          irq_o,
  output logic          int_rst_o,
  output logic          ext_rst_n_o
);
  localparam int PDW = $clog2(PD_TICKS + 1);

  logic wr_ctrl, wr_svc, wr_irq, wr_misc;
  assign wr_ctrl = wr_en_i & (addr_i == OFS_CTRL);
  assign wr_svc  = wr_en_i & (addr_i == OFS_SVC);
  assign wr_irq  = wr_en_i & (addr_i == OFS_IRQ);
  assign wr_misc = wr_en_i & (addr_i == OFS_MISC);

  logic [FW-1:0] tmo_q, pre_q, cnt_q;
  logic route_q, en_q, en_d, susp_q, susp_lock_q, swr_pend_q;
  logic ien_q, flag_q, tout_q, swsrc_q, pd_on_q;
  logic [PDW-1:0] pd_cnt_q;

  logic kick, half, run, en_rise, expire, load_c;
  logic swr_fire, ext_wr, pd_fire, int_start, ext_start, ext_act;

  assign en_rise = en_q & ~en_d;
  assign run     = en_q & ~(susp_q & lowpwr_i);
  assign expire  = half & (cnt_q == '0);
  assign load_c  = en_rise | kick | expire;

  wdt_prescale #(.TPH(TICKS_PER_HALF)) i_pre (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run),
    .clr_i(en_rise | kick), .half_o(half)
  );

  wdt_svc_seq i_svc (
    .clk(clk), .rst(rst), .wr_i(wr_svc), .data_i(wr_data_i), .kick_o(kick)
  );

  // control register and write-once locks
  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q <= '0; route_q <= 1'b0; en_q <= 1'b0; en_d <= 1'b0;
      susp_q <= 1'b0; susp_lock_q <= 1'b0;
    end else begin
      en_d <= en_q;
      if (wr_ctrl) begin
        tmo_q   <= wr_data_i[15:8];
        route_q <= wr_data_i[B_ROUTE];
        if (wr_data_i[B_EN]) en_q <= 1'b1;
        if (!susp_lock_q) begin
          susp_q      <= wr_data_i[B_SUSP];
          susp_lock_q <= 1'b1;
        end
      end
    end
  end

  // half-second down counter
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load_c) cnt_q <= tmo_q;
    else if (half) cnt_q <= cnt_q - 1'b1;
  end

  // software reset needs two writes within one tick period
  assign swr_fire = wr_ctrl & ~wr_data_i[B_SWRN] & swr_pend_q;
  assign ext_wr   = wr_ctrl & ~wr_data_i[B_EXTN];

  always_ff @(posedge clk) begin
    if (rst) swr_pend_q <= 1'b0;
    else if (wr_ctrl && !wr_data_i[B_SWRN]) swr_pend_q <= ~swr_pend_q;
    else if (tick_i) swr_pend_q <= 1'b0;
  end

  // power-up counter with permanent disable
  assign pd_fire = tick_i & pd_on_q & (pd_cnt_q == PDW'(PD_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_on_q  <= 1'b1;
      pd_cnt_q <= '0;
    end else begin
      if (wr_misc && wr_data_i == '0) pd_on_q <= 1'b0;
      if (tick_i && pd_cnt_q != PDW'(PD_TICKS)) pd_cnt_q <= pd_cnt_q + 1'b1;
    end
  end

  // pretimeout interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0; pre_q <= '0; flag_q <= 1'b0; irq_o <= 1'b0;
    end else begin
      if (wr_irq) begin
        ien_q <= wr_data_i[B_IEN];
        pre_q <= wr_data_i[7:0];
        if (wr_data_i[B_IFLG]) flag_q <= 1'b0;
      end
      if (half && ien_q && cnt_q == pre_q) flag_q <= 1'b1;
      irq_o <= ien_q & flag_q;
    end
  end

  // reset cause
  always_ff @(posedge clk) begin
    if (rst) begin
      tout_q <= 1'b0; swsrc_q <= 1'b0;
    end else if (swr_fire) begin
      tout_q <= 1'b0; swsrc_q <= 1'b1;
    end else if (expire) begin
      tout_q <= 1'b1; swsrc_q <= 1'b0;
    end
  end

  assign int_start = (expire & ~route_q) | swr_fire;
  assign ext_start = (expire & route_q) | ext_wr | pd_fire;

  wdt_pulse #(.LEN(PULSE_TICKS)) i_int_pulse (
    .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(int_start), .active_o(int_rst_o)
  );

  wdt_pulse #(.LEN(PULSE_TICKS)) i_ext_pulse (
    .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(ext_start), .active_o(ext_act)
  );

  assign ext_rst_n_o = ~ext_act;

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else begin
      unique case (addr_i)
        OFS_CTRL: rd_data_o <= {tmo_q, 2'b00, 1'b1, 1'b1, route_q, en_q, 1'b0, susp_q};
        OFS_STAT: rd_data_o <= {14'd0, tout_q, swsrc_q};
        OFS_IRQ:  rd_data_o <= {ien_q, flag_q, 6'd0, pre_q};
        OFS_MISC: rd_data_o <= {15'd0, pd_on_q};
        default:  rd_data_o <= '0;
      endcase
    end
  end

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (rst)
    en_q |=> en_q); // R5
  AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    susp_lock_q |=> $stable(susp_q)); // R6
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (susp_q && lowpwr_i && !load_c) |=> $stable(cnt_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !kick) |=> $stable(cnt_q)); // R2
  AST_PD_OFF_STAYS: assert property (@(posedge clk) disable iff (rst)
    !pd_on_q |=> !pd_on_q); // R13
endmodule

// File: tb/test_lf_watchdog.sv
module test_lf_watchdog;
  localparam int TPH = 4;
  localparam int PUL = 4;
  localparam int PDT = 20;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, lowpwr = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq, int_rst, ext_rst_n;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  lf_watchdog #(.TICKS_PER_HALF(TPH), .PULSE_TICKS(PUL), .PD_TICKS(PDT)) i_lf_watchdog (
    .clk(clk), .rst(rst), .tick_i(tick), .lowpwr_i(lowpwr), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq),
    .int_rst_o(int_rst), .ext_rst_n_o(ext_rst_n)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic do_rst();
    rst = 1'b1; repeat (3) @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic tk();
    tick = 1'b1; @(posedge clk); #1 tick = 1'b0; repeat (2) @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d; @(posedge clk); #1 wr_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    addr = a; @(posedge clk); #1 v = int'(rdata);
  endtask

  function automatic logic [15:0] cv(input int t, input bit route, input bit en, input bit susp);
    return {8'(t), 2'b00, 1'b1, 1'b1, route, en, 1'b0, susp};
  endfunction

  task automatic setup(input int t, input bit route, input bit susp, input logic [15:0] irqv);
    do_rst(); wr(4'h8, 16'h0); wr(4'h6, irqv); wr(4'h0, cv(t, route, 1'b1, susp));
  endtask

  task automatic fire_after(input bit use_ext, input int lim, output int k);
    bit prev, now;
    prev = use_ext ? !ext_rst_n : int_rst;
    k = -1;
    for (int i = 1; i <= lim; i++) begin
      tk();
      now = use_ext ? !ext_rst_n : int_rst;
      if (now && !prev) begin k = i; break; end
      prev = now;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, k;
    do_rst();
    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl", v, 16'h0030);
    rd(4'h4, v); chk("R1 stat", v, 0);
    rd(4'h6, v); chk("R1 irqctl", v, 0);
    rd(4'h8, v); chk("R1 misc", v, 1);
    chk("R1 outputs", {int_rst, ext_rst_n, irq}, 3'b010);

    // R2 / R8 sweep of timeout and pretimeout
    for (int n = 0; n <= 5; n++) begin
      for (int p = 0; p <= n; p++) begin
        int irq_k, fire_k;
        setup(n, 1'b0, 1'b0, 16'h8000 | 16'(p));
        irq_k = -1; fire_k = -1;
        for (int i = 1; i <= (n + 1) * TPH; i++) begin
          tk();
          if (irq && irq_k < 0) irq_k = i;
          if (int_rst && fire_k < 0) fire_k = i;
        end
        chk("R2 expiry tick", fire_k, (n + 1) * TPH);
        chk("R8 pretimeout tick", irq_k, (n - p + 1) * TPH);
      end
    end
    wr(4'h6, 16'hC005);
    rd(4'h6, v); chk("R8 flag cleared", v, 16'h8005);
    chk("R8 irq low after clear", irq, 0);
    setup(3, 1'b0, 1'b0, 16'h0002);
    k = 0;
    for (int i = 0; i < 16; i++) begin tk(); if (irq) k = 1; end
    chk("R8 disabled irq", k, 0);
    rd(4'h6, v); chk("R8 disabled flag", v, 16'h0002);

    // R3 service reload and R9 internal pulse width, R10 status
    setup(2, 1'b0, 1'b0, 16'h0);
    repeat (7) tk();
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    fire_after(1'b0, 20, k); chk("R3 reload", k, 12);
    chk("R9 ext idle on int route", ext_rst_n, 1);
    rd(4'h4, v); chk("R10 stat expiry", v, 2);
    repeat (3) tk(); chk("R9 int still high", int_rst, 1);
    tk(); chk("R9 int width", int_rst, 0);

    // R4 bad sequences
    setup(2, 1'b0, 1'b0, 16'h0);
    repeat (5) tk();
    wr(4'h2, 16'hAAAA); wr(4'h2, 16'h5555);
    fire_after(1'b0, 20, k); chk("R4 wrong order", k, 7);
    setup(2, 1'b0, 1'b0, 16'h0);
    repeat (5) tk();
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    fire_after(1'b0, 20, k); chk("R4 broken pair", k, 7);

    // R5 / R6 locks
    setup(2, 1'b0, 1'b1, 16'h0);
    wr(4'h0, cv(2, 1'b0, 1'b0, 1'b0));
    rd(4'h0, v); chk("R5 R6 ctrl readback", v, 16'h0235);
    fire_after(1'b0, 20, k); chk("R5 still running", k, 12);
    setup(2, 1'b0, 1'b0, 16'h0);
    wr(4'h0, cv(2, 1'b0, 1'b1, 1'b1));
    rd(4'h0, v); chk("R6 late suspend ignored", v & 1, 0);

    // R7 pause
    setup(2, 1'b0, 1'b1, 16'h0);
    repeat (3) tk();
    lowpwr = 1'b1;
    k = 0;
    for (int i = 0; i < 6; i++) begin tk(); if (int_rst) k = 1; end
    lowpwr = 1'b0;
    chk("R7 no expiry while paused", k, 0);
    fire_after(1'b0, 20, k); chk("R7 resume", k, 9);
    setup(2, 1'b0, 1'b0, 16'h0);
    lowpwr = 1'b1;
    fire_after(1'b0, 20, k); chk("R7 no pause without suspend", k, 12);
    lowpwr = 1'b0;

    // R14 timeout rewrite
    setup(2, 1'b0, 1'b0, 16'h0);
    repeat (2) tk();
    wr(4'h0, cv(5, 1'b0, 1'b1, 1'b0));
    fire_after(1'b0, 20, k); chk("R14 current period", k, 10);
    fire_after(1'b0, 40, k); chk("R14 next period", k, 24);

    // R9 external route, R10
    setup(1, 1'b1, 1'b0, 16'h0);
    fire_after(1'b1, 20, k); chk("R9 ext expiry", k, 8);
    chk("R9 int idle on ext route", int_rst, 0);
    rd(4'h4, v); chk("R10 stat ext expiry", v, 2);
    repeat (3) tk(); chk("R9 ext still low", ext_rst_n, 0);
    tk(); chk("R9 ext width", ext_rst_n, 1);

    // R11 software reset
    do_rst(); wr(4'h8, 16'h0);
    wr(4'h0, 16'h0020); wr(4'h0, 16'h0020);
    chk("R11 double write", int_rst, 1);
    rd(4'h4, v); chk("R10 stat software", v, 1);
    do_rst(); wr(4'h8, 16'h0);
    wr(4'h0, 16'h0020); tk(); wr(4'h0, 16'h0020);
    k = int_rst;
    repeat (3) begin tk(); if (int_rst) k = 1; end
    chk("R11 split writes", k, 0);
    rd(4'h4, v); chk("R11 stat untouched", v, 0);

    // R12 external reset request
    do_rst(); wr(4'h8, 16'h0);
    wr(4'h0, 16'h0010);
    chk("R12 ext low", ext_rst_n, 0);
    chk("R12 int idle", int_rst, 0);
    repeat (4) tk(); chk("R12 ext width", ext_rst_n, 1);

    // R13 power-up counter
    do_rst();
    fire_after(1'b1, 30, k); chk("R13 power-up fires", k, PDT);
    do_rst();
    wr(4'h8, 16'h0);
    rd(4'h8, v); chk("R13 disabled", v, 0);
    wr(4'h8, 16'h0001);
    rd(4'h8, v); chk("R13 stays disabled", v, 0);
    fire_after(1'b1, 30, k); chk("R13 no pulse", k, -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule